// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block sits on the read path of an embedded nonvolatile memory. While the internal engine is running a byte program or an erase, a read must not return array contents. It must return a status byte that software can poll. The block watches the engine's busy flag, the kind of operation, the top bit of the byte being programmed and the engine's pulse-limit overflow flag. From these it builds that status byte. When no operation is pending it passes the array data straight through.

The status byte carries three live bits:
- **Bit 7 (polling bit):** during a program it is the inverse of the written byte's top bit; during an erase it is 0.
- **Bit 6 (toggle bit):** it flips once for every completed read strobe.
- **Bit 5 (limit bit):** it is set when the engine reports that its pulse limit was exceeded.

Bits 4..0 read 0. Once the limit bit is set, the status byte stays on the bus until an identification-exit command is seen, even after the engine drops busy.

The controller has four states:
- **READ:** pass-through mode.
- **PROG:** a byte program is running.
- **ERASE:** an erase is running.
- **FAIL:** the limit was exceeded and the status is held.

It has six transitions:
- **start_prog:** READ→PROG, taken when busy is seen with kind = program.
- **start_erase:** READ→ERASE, taken when busy is seen with kind = erase.
- **limit_hit:** PROG/ERASE→FAIL, taken on the limit flag. It has priority over done.
- **done:** PROG/ERASE→READ, taken when busy drops.
- **exit:** FAIL→READ, taken on the exit command.
- **stay:** every other case leaves the state unchanged.

All inputs are sampled on the rising clock edge. The toggle bit advances when the active-low read strobe `rd_n` is sampled high after having been sampled low.

Top module: `status_byte_gen`

## Requirements
- R1: After reset the block is in READ: `stat_sel` is 0, `rd_data` equals `array_q`, and the toggle bit's stored value is 0.
- R2: When `eng_busy` is sampled 1 in READ with `eng_erase` = 0, then from the next cycle `stat_sel` is 1. In that case bit 7 of `rd_data` is the inverse of the `eng_msb` value sampled at that edge, and bits 5..0 except bit 6 are 0.
- R3: When the operation starts with `eng_erase` = 1, bit 7 of the status byte is 0 for the whole operation.
- R4: In PROG or ERASE, an edge at which `rd_n` is sampled 1 after being sampled 0 at the previous edge inverts bit 6 from the next cycle. At no other time does bit 6 change, and its value carries over from one operation to the next.
- R5: In PROG or ERASE, `eng_busy` sampled 0 with `eng_limit` = 0 returns the block to READ in the next cycle, with `rd_data` = `array_q`.
- R6: `eng_limit` sampled 1 in PROG or ERASE moves the block to FAIL, even if busy drops in the same cycle. In FAIL, bit 5 is 1, and bits 7 and 6 keep their values and ignore `rd_n` and busy. The block stays in FAIL until `exit_cmd` is sampled 1, and it is in READ in the following cycle.
- R7: `exit_cmd` has no effect in PROG or ERASE: the status byte stays selected.
- R8: Changes on `eng_msb` and `eng_erase` after the start edge have no effect on bit 7 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_busy | input | 1 | Engine is running an operation |
| eng_erase | input | 1 | Operation kind: 1 = erase, 0 = program |
| eng_msb | input | 1 | Top bit of the byte being programmed |
| eng_limit | input | 1 | Engine pulse-count limit exceeded |
| exit_cmd | input | 1 | Identification-exit command decoded |
| rd_n | input | 1 | Active-low read strobe |
| array_q | input | DATA_W | Array read data |
| rd_data | output | DATA_W | Byte returned to the reader |
| stat_sel | output | 1 | 1 when `rd_data` carries the status byte |

## Verification
A wrong state register is visible on the next cycle. It shows up as `stat_sel` taking the wrong value, or as bit 5 appearing or vanishing. Because of this, every cycle's output is compared against a bench model.

A corrupted polling bit shows immediately on bit 7 while the status byte is selected. A toggle flop that advances at the wrong moment, or fails to advance, shows one cycle after the strobe edge that should have moved it.

Some faults are hidden until later:
- A toggle value that is wrong while the block is in READ stays hidden until the next operation starts.
- A lost FAIL state shows as array data appearing before the exit command.

// File: rtl/stat_pkg.sv
package stat_pkg;
    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_FAIL  = 2'd3
    } stat_state_e;
endpackage

// File: rtl/stat_fsm.sv
module stat_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eng_busy,
    input  logic eng_erase,
    input  logic eng_msb,
    input  logic eng_limit,
    input  logic exit_cmd,
    output logic poll_o,
    output logic running_o,
    output logic failed_o
);
    stat_state_e state_q, state_d;
    logic        poll_q, poll_d;

    // next-state and polling-bit capture
    always_comb begin
        state_d = state_q;
        poll_d  = poll_q;
        unique case (state_q)
            ST_READ: begin
                if (eng_busy) begin
                    state_d = eng_erase ? ST_ERASE : ST_PROG;
                    poll_d  = eng_erase ? 1'b0 : ~eng_msb;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (eng_limit)      state_d = ST_FAIL;
                else if (!eng_busy) state_d = ST_READ;
            end
            ST_FAIL: begin
                if (exit_cmd) state_d = ST_READ;
            end
            default: state_d = ST_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            poll_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            poll_q  <= poll_d;
        end
    end

    // outputs
    always_comb begin
        running_o = 1'b0;
        failed_o  = 1'b0;
        unique case (state_q)
            ST_PROG, ST_ERASE: running_o = 1'b1;
            ST_FAIL:           failed_o  = 1'b1;
            default:           ;
        endcase
        poll_o = poll_q;
    end
endmodule

// File: rtl/stat_toggle.sv
module stat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic rd_n,
    output logic tog_o
);
    logic rdn_q;
    logic tog_q;
    logic strobe_end;

    assign strobe_end = rd_n & ~rdn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdn_q <= 1'b1;
            tog_q <= 1'b0;
        end else begin
            rdn_q <= rd_n;
            if (run_i && strobe_end) tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;
endmodule

// File: rtl/stat_mux.sv
module stat_mux #(
    parameter int DATA_W = 8
) (
    input  logic              run_i,
    input  logic              fail_i,
    input  logic              poll_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_sel
);
    localparam int POLL_POS = DATA_W - 1;
    localparam int TOG_POS  = DATA_W - 2;
    localparam int LIM_POS  = DATA_W - 3;

    always_comb begin
        stat_sel = run_i | fail_i;
        if (stat_sel) begin
            rd_data           = '0;
            rd_data[POLL_POS] = poll_i;
            rd_data[TOG_POS]  = tog_i;
            rd_data[LIM_POS]  = fail_i;
        end else begin
            rd_data = array_q;
        end
    end
endmodule

// File: rtl/status_byte_gen.sv
module status_byte_gen #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_busy,
    input  logic              eng_erase,
    input  logic              eng_msb,
    input  logic              eng_limit,
    input  logic              exit_cmd,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] array_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_sel
);
    logic poll, running, failed, tog;

    stat_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_erase(eng_erase),
        .eng_msb(eng_msb), .eng_limit(eng_limit), .exit_cmd(exit_cmd),
        .poll_o(poll), .running_o(running), .failed_o(failed)
    );

    stat_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .run_i(running), .rd_n(rd_n), .tog_o(tog)
    );

    stat_mux #(.DATA_W(DATA_W)) u_mux (
        .run_i(running), .fail_i(failed), .poll_i(poll), .tog_i(tog),
        .array_q(array_q), .rd_data(rd_data), .stat_sel(stat_sel)
    );
endmodule

// File: rtl/stat_checker.sv
module stat_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eng_busy,
    input logic              eng_limit,
    input logic              exit_cmd,
    input logic              rd_n,
    input logic [DATA_W-1:0] array_q,
    input logic [DATA_W-1:0] rd_data,
    input logic              stat_sel
);
    logic rdn_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdn_seen <= 1'b1;
        else        rdn_seen <= rd_n;
    end

    assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_sel |-> rd_data == array_q);

    assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_sel |-> rd_data[DATA_W-4:0] == '0);

    assert_fail_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel && rd_data[DATA_W-3] && !exit_cmd) |=> (stat_sel && rd_data[DATA_W-3]));

    assert_fail_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel && rd_data[DATA_W-3] && exit_cmd) |=> !stat_sel);

    assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel && !rd_data[DATA_W-3] && eng_busy && !eng_limit && rd_n && !rdn_seen)
        |=> rd_data[DATA_W-2] != $past(rd_data[DATA_W-2]));

    assert_exit_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel && !rd_data[DATA_W-3] && eng_busy && exit_cmd) |=> stat_sel);
endmodule

bind status_byte_gen stat_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_limit(eng_limit),
    .exit_cmd(exit_cmd), .rd_n(rd_n), .array_q(array_q), .rd_data(rd_data),
    .stat_sel(stat_sel)
);

// File: tb/tb_status_byte_gen.sv
`timescale 1ns/1ps
module tb_status_byte_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eng_busy = 0, eng_erase = 0, eng_msb = 0, eng_limit = 0, exit_cmd = 0, rd_n = 1;
    logic [7:0] array_q = 8'h00;
    logic [7:0] rd_data;
    logic       stat_sel;

    int checks = 0;
    int fails  = 0;

    // bench model: mode 0 read, 1 running, 2 fail
    int   m_mode = 0;
    logic m_poll = 0, m_tog = 0, m_prev = 1, m_erase = 0;

    always #2.5 clk = ~clk;

    status_byte_gen dut (
        .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_erase(eng_erase),
        .eng_msb(eng_msb), .eng_limit(eng_limit), .exit_cmd(exit_cmd),
        .rd_n(rd_n), .array_q(array_q), .rd_data(rd_data), .stat_sel(stat_sel)
    );

    function automatic logic [7:0] exp_byte();
        if (m_mode == 0) return array_q;
        return {m_poll, m_tog, (m_mode == 2), 5'b0};
    endfunction

    task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got sel/data %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string auto_tag(input logic [7:0] e);
        if (m_mode == 0)          return "R5";
        if (rd_data[7] !== e[7])  return m_erase ? "R3" : "R2";
        if (rd_data[6] !== e[6])  return "R4";
        if (rd_data[5] !== e[5])  return "R6";
        return "R2";
    endfunction

    task automatic model_edge();
        if (m_mode != 0 && m_mode != 2 && rd_n && !m_prev) m_tog = ~m_tog;
        m_prev = rd_n;
        case (m_mode)
            0: if (eng_busy) begin
                   m_mode = 1; m_erase = eng_erase;
                   m_poll = eng_erase ? 1'b0 : ~eng_msb;
               end
            1: if (eng_limit) m_mode = 2; else if (!eng_busy) m_mode = 0;
            default: if (exit_cmd) m_mode = 0;
        endcase
    endtask

    task automatic cyc(input logic b, input logic er, input logic msb,
                       input logic lim, input logic ex, input logic rn);
        logic [7:0] e;
        eng_busy = b; eng_erase = er; eng_msb = msb;
        eng_limit = lim; exit_cmd = ex; rd_n = rn;
        array_q = 8'($urandom);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        e = exp_byte();
        chk(auto_tag(e), {stat_sel, rd_data}, {(m_mode != 0), e});
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] saved;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        array_q = 8'hA5;
        #1;
        chk("R1", {stat_sel, rd_data}, {1'b0, 8'hA5});
        rst_n = 1'b1;
        @(negedge clk);

        // R2: program with top bit 1, then strobes toggling bit 6 (R4)
        cyc(1, 0, 1, 0, 0, 1);
        chk("R2", {stat_sel, rd_data}, {1'b1, 8'h00});
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 1);
        chk("R4", {stat_sel, rd_data}, {1'b1, 8'h40});
        // R8: kind and data change mid-operation ignored
        cyc(1, 1, 0, 0, 0, 1);
        chk("R8", {stat_sel, rd_data}, {1'b1, 8'h40});
        // R7: exit during running ignored
        cyc(1, 0, 0, 0, 1, 1);
        chk("R7", {8'h00, stat_sel}, {8'h00, 1'b1});
        // R5: done
        cyc(0, 0, 0, 0, 0, 1);
        chk("R5", {stat_sel, rd_data}, {1'b0, array_q});

        // R3: erase, toggle carried over (R4)
        cyc(1, 1, 0, 0, 0, 1);
        chk("R3", {stat_sel, rd_data}, {1'b1, 8'h40});
        cyc(1, 1, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 1);
        chk("R4", {stat_sel, rd_data}, {1'b1, 8'h00});

        // R6: limit with busy dropping in same cycle; held through strobes
        cyc(0, 1, 0, 1, 0, 0);
        chk("R6", {stat_sel, rd_data}, {1'b1, 8'h20});
        cyc(0, 0, 1, 0, 0, 1);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 1);
        saved = rd_data;
        chk("R6", {stat_sel, saved}, {1'b1, 8'h20});
        cyc(0, 0, 0, 0, 1, 1);
        chk("R6", {stat_sel, rd_data}, {1'b0, array_q});

        // program with top bit 0 -> polling bit 1
        cyc(1, 0, 0, 0, 0, 1);
        chk("R2", {stat_sel, rd_data[7]}, {1'b1, 1'b1});
        cyc(0, 0, 0, 0, 0, 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic b, lim, ex;
            b   = (m_mode == 0) ? ($urandom_range(0, 5) == 0)
                                : ($urandom_range(0, 9) != 0);
            lim = ($urandom_range(0, 39) == 0);
            ex  = ($urandom_range(0, 19) == 0);
            cyc(b, 1'($urandom), 1'($urandom), lim, ex, ($urandom_range(0, 2) != 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule